// File: doc/BRIEF.md
# Oversampled 8N1 Serial Receiver with Sticky Framing Error

This block receives an asynchronous serial stream made of one start bit, eight data bits sent least significant bit first, no parity and one stop bit. A fractional divider makes a sampling tick at eight times the baud rate. The raw line first passes through a two-flop synchronizer. On a tick where the idle receiver sees the line low, it takes that tick as the start edge. It samples data bit 0 twelve ticks later, which is the middle of that bit, and then samples each further bit eight ticks after the one before. The stop bit is sampled eight ticks after the last data bit.

When the stop bit reads high, the byte is written to an eight-entry receive FIFO and the receiver starts looking for the next start edge on the next tick. When the stop bit reads low, the frame is a framing error or a break. The byte is thrown away, a sticky error flag is raised, and the receiver waits until the line reads high before it looks for a start edge again. A write into a full FIFO drops the byte and raises a sticky overrun flag. One clear strobe lowers both sticky flags.

The divider takes a 16-bit integer part and an 8-bit fractional part, so the value is in units of 1/256 of a system clock. To get a given baud rate, program it to system clock / (8 × baud).

Top module: `rx_frame_unit`

## Requirements
- R1: After reset, `empty` is 1 and both `err_flag` and `ovr_flag` are 0.
- R2: For every byte value, a frame with a high stop bit makes that byte readable on `rd_data` once the frame has finished. Bit 0 is the first bit sent after the start bit.
- R3: The start bit is not checked for validity. A low pulse as short as three system clocks on an idle line, with the line high afterwards, is received as the byte 0xFF.
- R4: After a good stop bit the receiver re-arms at once, so frames sent back to back with no idle time between them are all received, in order.
- R5: A frame whose stop bit reads low is not written to the FIFO, and it sets `err_flag`.
- R6: After a bad stop bit the receiver does not look for a start edge until the line reads high. A break that lasts many frame times yields no further error once the flag has been cleared during the break. The first good frame after the line returns high is received.
- R7: `err_flag` stays at 1 until `flag_clr` is pulsed. If an error occurs in the same cycle as `flag_clr`, the flag is still set.
- R8: The FIFO holds 8 bytes and returns them first in, first out. `rd_data` shows the oldest byte while `empty` is 0, and `pop` removes that byte. A `pop` while `empty` is 1 has no effect.
- R9: A good frame that arrives while the FIFO holds 8 bytes is dropped and sets `ovr_flag`. The 8 bytes already stored are kept. `flag_clr` lowers `ovr_flag`.
- R10: The tick period is {`div_int`,`div_frac`}/256 system clocks, with a long-term average that is exact. A value below 1.0 acts as 1.0. Frames at 8 × 2.5 and 8 × 3 clocks per bit are received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_line | input | 1 | Raw serial line, high when idle |
| div_int | input | 16 | Integer part of the divider for the 8×-baud tick |
| div_frac | input | 8 | Fractional part of the divider, in 1/256 steps |
| flag_clr | input | 1 | One-cycle strobe that clears the error and overrun flags |
| pop | input | 1 | Removes the oldest byte from the FIFO |
| rd_data | output | 8 | Oldest byte in the FIFO |
| empty | output | 1 | FIFO holds no byte |
| err_flag | output | 1 | Sticky framing or break flag |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bench sends all 256 byte values, so any bit-order or bit-shift slip shows up as a wrong `rd_data`. It sends a three-clock glitch that must come out as 0xFF, and frames back to back that a receiver waiting out the full stop bit would misalign. During a long break it clears the error flag. A receiver that re-arms while the line is still low raises the flag again there, and one that never leaves its hold state misses the next frame. The bench holds `flag_clr` high while an error arrives, fills the FIFO past its depth, pops while the FIFO is empty, and runs at fractional and below-one divider settings. These catch a clear that wins over a new error, lost order or overwritten entries, corrupted pointers, and drifting tick spacing.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  localparam int DATA_W     = 8;
  localparam int TPB        = 8;
  localparam int FIRST_DLY  = 12;
  localparam int DIV_INT_W  = 16;
  localparam int DIV_FRAC_W = 8;
  localparam int FIFO_DEPTH = 8;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DATA = 2'd1,
    S_STOP = 2'd2,
    S_HOLD = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rxu_sync.sv
module rxu_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rxu_tick_gen.sv
module rxu_tick_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  localparam int DW = INT_W + FRAC_W;
  localparam logic [DW-1:0] ONE = DW'(1) << FRAC_W;

  logic [DW-1:0] div_raw, div_eff, acc_q, acc_d;
  logic [DW:0]   sum;

  assign div_raw = {div_int, div_frac};
  assign div_eff = (div_raw < ONE) ? ONE : div_raw;
  assign sum     = {1'b0, acc_q} + {1'b0, ONE};

  always_comb begin
    tick  = 1'b0;
    acc_d = acc_q + ONE;
    if (acc_q >= div_eff) begin
      acc_d = '0;
    end else if (sum >= {1'b0, div_eff}) begin
      tick  = 1'b1;
      acc_d = DW'(sum - {1'b0, div_eff});
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    ($stable(div_raw) && (acc_q < div_eff)) |=> (acc_q < div_eff)); // R10
endmodule

// File: rtl/rxu_deframer.sv
module rxu_deframer
  import rxu_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int TB    = TPB,
  parameter int FIRST = FIRST_DLY
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         tick,
  input  logic         rx_s,
  output logic         push,
  output logic [W-1:0] push_data,
  output logic         err_set
);
  localparam int CNT_W = $clog2(FIRST);
  localparam int BIT_W = $clog2(W);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [W-1:0]     sr_q, sr_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sr_d    = sr_q;
    push    = 1'b0;
    err_set = 1'b0;
    if (tick) begin
      unique case (state_q)
        S_IDLE: if (!rx_s) begin
          cnt_d   = CNT_W'(FIRST - 1);
          bit_d   = '0;
          state_d = S_DATA;
        end
        S_DATA: if (cnt_q == '0) begin
          sr_d  = {rx_s, sr_q[W-1:1]};
          cnt_d = CNT_W'(TB - 1);
          if (bit_q == BIT_W'(W - 1)) state_d = S_STOP;
          else                        bit_d   = bit_q + 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
        S_STOP: if (cnt_q == '0) begin
          if (rx_s) begin
            push    = 1'b1;
            state_d = S_IDLE;
          end else begin
            err_set = 1'b1;
            state_d = S_HOLD;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
        S_HOLD: if (rx_s) state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sr_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sr_q    <= sr_d;
    end
  end

  assign push_data = sr_q;

  AST_PUSH_GOOD_STOP: assert property (@(posedge clk) disable iff (!rst_ni)
    push |-> rx_s); // R5
  AST_ERR_BAD_STOP: assert property (@(posedge clk) disable iff (!rst_ni)
    err_set |-> (!rx_s && !push)); // R5
  AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_HOLD && !rx_s) |=> (state_q == S_HOLD)); // R6
endmodule

// File: rtl/rxu_fifo.sv
module rxu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  input  logic         clr,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         ovr
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wptr_q, rptr_q, wptr_d, rptr_d;
  logic         full, do_wr, do_rd, ovr_d;

  assign empty = (wptr_q == rptr_q);
  assign full  = (wptr_q[PW] != rptr_q[PW]) && (wptr_q[PW-1:0] == rptr_q[PW-1:0]);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;

  always_comb begin
    wptr_d = do_wr ? wptr_q + 1'b1 : wptr_q;
    rptr_d = do_rd ? rptr_q + 1'b1 : rptr_q;
    ovr_d  = ovr;
    if (clr)          ovr_d = 1'b0;
    if (push && full) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      ovr    <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      ovr    <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q[PW-1:0]] <= wdata;
  end

  assign rdata = mem[rptr_q[PW-1:0]];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    ((wptr_q - rptr_q) <= (PW+1)'(DEPTH))); // R8
  AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop && empty && !push) |=> ($stable(rptr_q) && empty)); // R8
  AST_OVR_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_ni)
    (push && full) |=> (ovr && $stable(wptr_q))); // R9
endmodule

// File: rtl/rx_frame_unit.sv
module rx_frame_unit
  import rxu_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int INT_W  = DIV_INT_W,
  parameter int FRAC_W = DIV_FRAC_W,
  parameter int DEPTH  = FIFO_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              flag_clr,
  input  logic              pop,
  output logic [W-1:0]      rd_data,
  output logic              empty,
  output logic              err_flag,
  output logic              ovr_flag
);
  logic         rst_sn, rx_s, tick, push, err_set, err_d;
  logic [W-1:0] push_data;

  rxu_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_ni(rst_n), .d(1'b1), .q(rst_sn));

  rxu_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_ni(rst_sn), .d(rx_line), .q(rx_s));

  rxu_tick_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_tick (
    .clk(clk), .rst_ni(rst_sn), .div_int(div_int), .div_frac(div_frac),
    .tick(tick));

  rxu_deframer #(.W(W), .TB(TPB), .FIRST(FIRST_DLY)) u_deframe (
    .clk(clk), .rst_ni(rst_sn), .tick(tick), .rx_s(rx_s),
    .push(push), .push_data(push_data), .err_set(err_set));

  rxu_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_ni(rst_sn), .push(push), .wdata(push_data),
    .pop(pop), .clr(flag_clr), .rdata(rd_data), .empty(empty),
    .ovr(ovr_flag));

  always_comb begin
    err_d = err_flag;
    if (flag_clr) err_d = 1'b0;
    if (err_set)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) err_flag <= 1'b0;
    else         err_flag <= err_d;
  end

  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_sn)
    err_set |=> err_flag); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    (err_flag && !flag_clr) |=> err_flag); // R7
endmodule

// File: tb/sim_rx_frame_unit.sv
module sim_rx_frame_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic [15:0] div_int = 16'd1;
  logic [7:0]  div_frac = 8'd0;
  logic        flag_clr = 1'b0;
  logic        pop = 1'b0;
  logic [7:0]  rd_data;
  logic        empty, err_flag, ovr_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit mon_en = 0;
  bit err_seen = 0;

  always #4 clk = ~clk;

  rx_frame_unit u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .div_int(div_int),
    .div_frac(div_frac), .flag_clr(flag_clr), .pop(pop), .rd_data(rd_data),
    .empty(empty), .err_flag(err_flag), .ovr_flag(ovr_flag));

  always @(negedge clk) if (mon_en && err_flag) err_seen = 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stopv, input int bc);
    @(negedge clk);
    rx_line = 1'b0; wclk(bc);
    for (int i = 0; i < 8; i++) begin rx_line = b[i]; wclk(bc); end
    rx_line = stopv; wclk(bc);
    rx_line = 1'b1;
  endtask

  task automatic do_pop;
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic clr_pulse;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    @(negedge clk);
    check(!empty && rd_data == v, tag, {23'd0, empty, rd_data}, {24'd0, v});
    do_pop();
  endtask

  initial begin
    wclk(3); rst_n = 1'b1; wclk(5);
    // R1 reset state
    check(empty == 1'b1, "R1 empty", empty, 1);
    check(err_flag == 1'b0, "R1 err_flag", err_flag, 0);
    check(ovr_flag == 1'b0, "R1 ovr_flag", ovr_flag, 0);

    // R8 pop on empty has no effect
    repeat (3) do_pop();
    check(empty == 1'b1, "R8 pop while empty", empty, 1);
    send(8'h3C, 1'b1, 8); wclk(8);
    expect_byte(8'h3C, "R8 after empty pops");
    check(empty == 1'b1, "R8 empty after pop", empty, 1);

    // R2 all byte values, divider 1.0
    for (int v = 0; v < 256; v++) begin
      send(v[7:0], 1'b1, 8); wclk(8);
      expect_byte(v[7:0], "R2 byte sweep");
    end

    // R3 short glitch taken as start
    @(negedge clk); rx_line = 1'b0; wclk(3); rx_line = 1'b1; wclk(100);
    expect_byte(8'hFF, "R3 glitch start");

    // R4 back to back frames
    for (int i = 0; i < 8; i++) send(8'(8'hA5 ^ (i * 37)), 1'b1, 8);
    wclk(16);
    for (int i = 0; i < 8; i++) expect_byte(8'(8'hA5 ^ (i * 37)), "R4 back to back");

    // R5 bad stop: dropped, flag set
    send(8'h5A, 1'b0, 8); wclk(16);
    check(err_flag == 1'b1, "R5 err_flag", err_flag, 1);
    check(empty == 1'b1, "R5 byte dropped", empty, 1);
    // R7 sticky until clear
    wclk(50);
    check(err_flag == 1'b1, "R7 sticky", err_flag, 1);
    clr_pulse(); wclk(1);
    check(err_flag == 1'b0, "R7 cleared", err_flag, 0);

    // R6 break with clear inside, then recovery
    @(negedge clk); rx_line = 1'b0; wclk(120);
    check(err_flag == 1'b1, "R6 break error", err_flag, 1);
    clr_pulse(); wclk(300);
    check(err_flag == 1'b0, "R6 no rearm while low", err_flag, 0);
    check(empty == 1'b1, "R6 no push in break", empty, 1);
    rx_line = 1'b1; wclk(16);
    send(8'hC3, 1'b1, 8); wclk(8);
    expect_byte(8'hC3, "R6 recovery frame");

    // R7 set wins over clear in same cycle
    @(negedge clk); flag_clr = 1'b1; err_seen = 0; mon_en = 1;
    send(8'h11, 1'b0, 8); wclk(16);
    mon_en = 0; flag_clr = 1'b0; wclk(1);
    check(err_seen == 1'b1, "R7 set beats clear", err_seen, 1);
    check(err_flag == 1'b0, "R7 cleared afterwards", err_flag, 0);

    // R9 overrun
    for (int i = 0; i < 9; i++) begin send(8'(i * 29 + 3), 1'b1, 8); wclk(2); end
    wclk(16);
    check(ovr_flag == 1'b1, "R9 ovr_flag", ovr_flag, 1);
    for (int i = 0; i < 8; i++) expect_byte(8'(i * 29 + 3), "R9 kept entries");
    check(empty == 1'b1, "R9 ninth dropped", empty, 1);
    clr_pulse(); wclk(1);
    check(ovr_flag == 1'b0, "R9 ovr cleared", ovr_flag, 0);

    // R10 fractional divider 2.5 and integer 3.0, below-one clamp
    @(negedge clk); div_int = 16'd2; div_frac = 8'd128; wclk(10);
    for (int v = 0; v < 16; v++) begin
      send(8'(v * 17 + 1), 1'b1, 20); wclk(20);
      expect_byte(8'(v * 17 + 1), "R10 divider 2.5");
    end
    @(negedge clk); div_int = 16'd3; div_frac = 8'd0; wclk(10);
    for (int v = 0; v < 16; v++) begin
      send(8'(v * 13 + 7), 1'b1, 24); wclk(24);
      expect_byte(8'(v * 13 + 7), "R10 divider 3.0");
    end
    @(negedge clk); div_int = 16'd0; div_frac = 8'd64; wclk(10);
    for (int v = 0; v < 4; v++) begin
      send(8'(v * 61 + 9), 1'b1, 8); wclk(8);
      expect_byte(8'(v * 61 + 9), "R10 below one");
    end
    check(err_flag == 1'b0, "R10 no errors", err_flag, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule